// File: doc/BRIEF.md
# Unified Stack and Register Memory Manager

This block turns a single single-port RAM of 512 words, 38 bits each, into four logical stores for a small stack-oriented controller: an operand stack, a return stack, a bank of global registers and a chain of per-call local register frames. A core issues one operation per cycle on `op_code`. The block works out which region and which word the operation touches, drives the RAM, moves the stack and frame pointers, and returns any read result one cycle later. That one-cycle delay is the latency of a synchronous block RAM.

The regions are laid out in a fixed order, and their sizes are set by parameters:

| Region | Words | Size |
|---|---|---|
| Operand stack | 0 to 31 | 32 entries |
| Return stack | 32 to 47 | 16 entries |
| Globals | 48 to 191 | 144 entries |
| Frame area | 192 upward | the rest |

A frame holds 24 local registers, so 13 frames fit in the frame area.

A call does two things. It stores the return address and the caller's frame number on the return stack, and it moves to the next frame. A return reads that entry back. For the cycle after a return the FSM leaves ST_RUN for ST_RESTORE. In ST_RESTORE it loads the saved frame number from the RAM output, holds `ready` low and ignores any request. It then goes back to ST_RUN.

When an operation is illegal, no RAM access happens, no pointer moves, and one of three sticky flags is set. The flags clear only on reset.

Top module: `ustk_mem_mgr`

## Requirements
- R1: After reset, `ready`=1, `rd_valid`=0, and `ovf_err`, `unf_err` and `idx_err` are all 0. The operand stack and the return stack are empty, and the current frame is frame 0.
- R2: Push (op 1) writes `wr_data` at word `depth`, then increments the depth. Pop (op 2) reads word `depth-1`, then decrements the depth. One cycle after the pop cycle, `rd_valid`=1 and `rd_data` holds the most recently pushed entry that is still on the stack.
- R3: A push when the operand stack already holds 32 entries performs no RAM access and sets `ovf_err`. The stack contents are unchanged.
- R4: A pop on an empty operand stack performs no RAM access, produces no `rd_valid` and sets `unf_err`.
- R5: Global write (op 6) and global read (op 5) use word 48+`reg_idx`. A global read returns the last value written to that index, one cycle later. An index of 144 or more is rejected: `idx_err` is set, and there is no access and no `rd_valid`.
- R6: Local write (op 8) and local read (op 7) use word 192 + 24*frame + `reg_idx`. An index of 24 or more is rejected in the same way as in R5.
- R7: Call (op 3) writes a word at 32+`return depth`. Bits [15:0] hold `ret_addr`, bits [19:16] hold the caller's frame number, and all higher bits are zero. The call then increments the return depth and moves to the next frame, so local writes in the callee do not alter the caller's locals.
- R8: Return (op 4) reads the top return entry. In the next cycle (ST_RESTORE), `ready`=0, `rd_valid`=1 and `rd_data` holds that entry. The caller's frame is restored, and any operation presented during ST_RESTORE is ignored.
- R9: A call when the frame area is exhausted (the current frame is the last, 12 at default sizes) or the return stack is full performs no RAM access, sets `ovf_err` and leaves the frame unchanged.
- R10: A return with an empty return stack performs no RAM access and no read, and sets `unf_err`.
- R11: Each error flag stays set until reset, and a rejected operation leaves all pointers unchanged.
- R12: At most one RAM access happens per cycle. `ram_we` is high only together with `ram_en`, and op 0 (no operation) causes no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 4 | Requested operation (0 none, 1 push, 2 pop, 3 call, 4 return, 5 global read, 6 global write, 7 local read, 8 local write) |
| reg_idx | input | 8 | Register index for global and local accesses |
| wr_data | input | 38 | Data for push and register writes |
| ret_addr | input | 16 | Return address stored by a call |
| ready | output | 1 | High in ST_RUN, when a request is accepted |
| rd_valid | output | 1 | Read result is valid this cycle |
| rd_data | output | 38 | Read result |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 9 | RAM word address |
| ram_wdata | output | 38 | RAM write data |
| ovf_err | output | 1 | Sticky overflow flag |
| unf_err | output | 1 | Sticky underflow flag |
| idx_err | output | 1 | Sticky bad-index flag |

## Verification
The bench builds the block with its default sizes: 32-entry operand stack, 16-entry return stack, 144 globals and 24-word frames. This gives 13 frames, so the frame area runs out at the thirteenth nested call, before the return stack fills. The full operand stack, the last valid and first invalid register indices, deep call nesting with frame restore, and operations presented during ST_RESTORE are all reachable. The return-stack-full path is not reached at these sizes.

// File: rtl/ustk_pkg.sv
package ustk_pkg;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_PUSH = 4'd1,
        OP_POP  = 4'd2,
        OP_CALL = 4'd3,
        OP_RET  = 4'd4,
        OP_GRD  = 4'd5,
        OP_GWR  = 4'd6,
        OP_ARD  = 4'd7,
        OP_AWR  = 4'd8
    } op_e;

    typedef enum logic {
        ST_RUN     = 1'b0,
        ST_RESTORE = 1'b1
    } state_e;

endpackage

// File: rtl/ustk_ram.sv
module ustk_ram #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 38,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                rdata <= mem[addr];
            end
        end
    end

endmodule

// File: rtl/ustk_addr.sv
module ustk_addr
    import ustk_pkg::*;
#(
    parameter int DS_DEPTH = 32,
    parameter int RS_DEPTH = 16,
    parameter int NGLOB    = 144,
    parameter int FRAME_SZ = 24,
    parameter int NFRAMES  = 13,
    parameter int AW       = 9,
    parameter int IDX_W    = 8,
    parameter int DSP_W    = 6,
    parameter int RSP_W    = 5,
    parameter int FP_W     = 4
) (
    input  op_e              op,
    input  logic [IDX_W-1:0] idx,
    input  logic [DSP_W-1:0] dsp,
    input  logic [RSP_W-1:0] rsp,
    input  logic [FP_W-1:0]  fp,
    output logic [AW-1:0]    addr,
    output logic             hit,
    output logic             wr,
    output logic             ovf,
    output logic             unf,
    output logic             bad
);

    localparam int DS_BASE = 0;
    localparam int RS_BASE = DS_BASE + DS_DEPTH;
    localparam int GR_BASE = RS_BASE + RS_DEPTH;
    localparam int FR_BASE = GR_BASE + NGLOB;

    logic [AW-1:0] frame_base;
    assign frame_base = AW'(FR_BASE) + AW'(fp) * AW'(FRAME_SZ);

    always_comb begin
        addr = '0;
        hit  = 1'b0;
        wr   = 1'b0;
        ovf  = 1'b0;
        unf  = 1'b0;
        bad  = 1'b0;
        unique case (op)
            OP_PUSH: begin
                if (32'(dsp) == DS_DEPTH) ovf = 1'b1;
                else begin
                    hit  = 1'b1;
                    wr   = 1'b1;
                    addr = AW'(DS_BASE) + AW'(dsp);
                end
            end
            OP_POP: begin
                if (dsp == '0) unf = 1'b1;
                else begin
                    hit  = 1'b1;
                    addr = AW'(DS_BASE) + AW'(dsp) - AW'(1);
                end
            end
            OP_CALL: begin
                if (32'(rsp) == RS_DEPTH || 32'(fp) == NFRAMES - 1) ovf = 1'b1;
                else begin
                    hit  = 1'b1;
                    wr   = 1'b1;
                    addr = AW'(RS_BASE) + AW'(rsp);
                end
            end
            OP_RET: begin
                if (rsp == '0) unf = 1'b1;
                else begin
                    hit  = 1'b1;
                    addr = AW'(RS_BASE) + AW'(rsp) - AW'(1);
                end
            end
            OP_GRD, OP_GWR: begin
                if (32'(idx) >= NGLOB) bad = 1'b1;
                else begin
                    hit  = 1'b1;
                    wr   = (op == OP_GWR);
                    addr = AW'(GR_BASE) + AW'(idx);
                end
            end
            OP_ARD, OP_AWR: begin
                if (32'(idx) >= FRAME_SZ) bad = 1'b1;
                else begin
                    hit  = 1'b1;
                    wr   = (op == OP_AWR);
                    addr = frame_base + AW'(idx);
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ustk_mem_mgr.sv
module ustk_mem_mgr
    import ustk_pkg::*;
#(
    parameter int WORD_W    = 38,
    parameter int MEM_DEPTH = 512,
    parameter int DS_DEPTH  = 32,
    parameter int RS_DEPTH  = 16,
    parameter int NGLOB     = 144,
    parameter int FRAME_SZ  = 24,
    parameter int RA_W      = 16,
    parameter int IDX_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [3:0]                   op_code,
    input  logic [IDX_W-1:0]             reg_idx,
    input  logic [WORD_W-1:0]            wr_data,
    input  logic [RA_W-1:0]              ret_addr,
    output logic                         ready,
    output logic                         rd_valid,
    output logic [WORD_W-1:0]            rd_data,
    output logic                         ram_en,
    output logic                         ram_we,
    output logic [$clog2(MEM_DEPTH)-1:0] ram_addr,
    output logic [WORD_W-1:0]            ram_wdata,
    output logic                         ovf_err,
    output logic                         unf_err,
    output logic                         idx_err
);

    localparam int AW      = $clog2(MEM_DEPTH);
    localparam int FR_BASE = DS_DEPTH + RS_DEPTH + NGLOB;
    localparam int NFRAMES = (MEM_DEPTH - FR_BASE) / FRAME_SZ;
    localparam int DSP_W   = $clog2(DS_DEPTH + 1);
    localparam int RSP_W   = $clog2(RS_DEPTH + 1);
    localparam int FP_W    = $clog2(NFRAMES);

    op_e              op;
    state_e           state, state_nx;
    logic [DSP_W-1:0] dsp;
    logic [RSP_W-1:0] rsp;
    logic [FP_W-1:0]  fp;
    logic             rd_pend, rd_go;
    logic [WORD_W-1:0] ram_q;

    logic [AW-1:0] a_addr;
    logic          a_hit, a_wr, a_ovf, a_unf, a_bad;

    assign op = op_e'(op_code);

    ustk_addr #(
        .DS_DEPTH(DS_DEPTH), .RS_DEPTH(RS_DEPTH), .NGLOB(NGLOB),
        .FRAME_SZ(FRAME_SZ), .NFRAMES(NFRAMES), .AW(AW), .IDX_W(IDX_W),
        .DSP_W(DSP_W), .RSP_W(RSP_W), .FP_W(FP_W)
    ) u_addr (
        .op(op), .idx(reg_idx), .dsp(dsp), .rsp(rsp), .fp(fp),
        .addr(a_addr), .hit(a_hit), .wr(a_wr),
        .ovf(a_ovf), .unf(a_unf), .bad(a_bad)
    );

    ustk_ram #(.DEPTH(MEM_DEPTH), .WIDTH(WORD_W), .AW(AW)) u_ram (
        .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
        .wdata(ram_wdata), .rdata(ram_q)
    );

    // State, pointer and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_RUN;
            dsp     <= '0;
            rsp     <= '0;
            fp      <= '0;
            rd_pend <= 1'b0;
            ovf_err <= 1'b0;
            unf_err <= 1'b0;
            idx_err <= 1'b0;
        end else begin
            state   <= state_nx;
            rd_pend <= rd_go;
            if (state == ST_RUN) begin
                ovf_err <= ovf_err | a_ovf;
                unf_err <= unf_err | a_unf;
                idx_err <= idx_err | a_bad;
                if (a_hit) begin
                    unique case (op)
                        OP_PUSH: dsp <= dsp + DSP_W'(1);
                        OP_POP:  dsp <= dsp - DSP_W'(1);
                        OP_CALL: begin
                            rsp <= rsp + RSP_W'(1);
                            fp  <= fp + FP_W'(1);
                        end
                        OP_RET:  rsp <= rsp - RSP_W'(1);
                        default: ;
                    endcase
                end
            end else begin
                fp <= ram_q[RA_W +: FP_W];
            end
        end
    end

    // Next state and RAM control
    always_comb begin
        state_nx  = state;
        ready     = (state == ST_RUN);
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = a_addr;
        ram_wdata = wr_data;
        rd_go     = 1'b0;
        unique case (state)
            ST_RUN: begin
                ram_en = a_hit;
                ram_we = a_hit && a_wr;
                rd_go  = a_hit && !a_wr;
                if (op == OP_CALL) ram_wdata = WORD_W'({fp, ret_addr});
                if (a_hit && op == OP_RET) state_nx = ST_RESTORE;
            end
            ST_RESTORE: state_nx = ST_RUN;
            default:    state_nx = ST_RUN;
        endcase
    end

    assign rd_valid = rd_pend;
    assign rd_data  = ram_q;

endmodule

// File: rtl/ustk_mem_mgr_chk.sv
module ustk_mem_mgr_chk
    import ustk_pkg::*;
#(
    parameter int DS_DEPTH = 32,
    parameter int RS_DEPTH = 16,
    parameter int NFRAMES  = 13,
    parameter int DSP_W    = 6,
    parameter int RSP_W    = 5,
    parameter int FP_W     = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       op_code,
    input logic             ready,
    input logic             rd_valid,
    input logic             ram_en,
    input logic             ram_we,
    input logic             ovf_err,
    input logic             unf_err,
    input logic             idx_err,
    input logic [DSP_W-1:0] dsp,
    input logic [RSP_W-1:0] rsp,
    input logic [FP_W-1:0]  fp
);

    logic call_blocked;
    assign call_blocked = (32'(fp) == NFRAMES - 1) || (32'(rsp) == RS_DEPTH);

    a_r1_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        32'(dsp) <= DS_DEPTH && 32'(rsp) <= RS_DEPTH && 32'(fp) < NFRAMES);

    a_r12_we_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ram_en);

    a_r12_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready || op_code == OP_NOP) |-> !ram_en);

    a_r2_pop_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && op_code == OP_POP && dsp != '0) |=> rd_valid);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && op_code == OP_PUSH && 32'(dsp) == DS_DEPTH) |=> ovf_err && dsp == $past(dsp));

    a_r4_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && op_code == OP_POP && dsp == '0) |=> unf_err && !rd_valid);

    a_r7_call_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && op_code == OP_CALL && !call_blocked) |=> fp == $past(fp) + FP_W'(1));

    a_r9_call_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && op_code == OP_CALL && call_blocked) |=> ovf_err && fp == $past(fp));

    a_r8_ret_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && op_code == OP_RET && rsp != '0) |=> !ready && rd_valid);

    a_r8_restore_once: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ready);

    a_r10_ret_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && op_code == OP_RET && rsp == '0) |-> !ram_en);

    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);

    a_r11_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        unf_err |=> unf_err);

    a_r11_idx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        idx_err |=> idx_err);

endmodule

bind ustk_mem_mgr ustk_mem_mgr_chk #(
    .DS_DEPTH(DS_DEPTH), .RS_DEPTH(RS_DEPTH), .NFRAMES(NFRAMES),
    .DSP_W(DSP_W), .RSP_W(RSP_W), .FP_W(FP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .ready(ready),
    .rd_valid(rd_valid), .ram_en(ram_en), .ram_we(ram_we),
    .ovf_err(ovf_err), .unf_err(unf_err), .idx_err(idx_err),
    .dsp(dsp), .rsp(rsp), .fp(fp)
);

// File: tb/ustk_mem_mgr_tb.sv
module ustk_mem_mgr_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  op_code;
    logic [7:0]  reg_idx;
    logic [37:0] wr_data;
    logic [15:0] ret_addr;
    logic        ready, rd_valid, ram_en, ram_we;
    logic [37:0] rd_data, ram_wdata;
    logic [8:0]  ram_addr;
    logic        ovf_err, unf_err, idx_err;

    ustk_mem_mgr u_dut (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .reg_idx(reg_idx),
        .wr_data(wr_data), .ret_addr(ret_addr), .ready(ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .ram_en(ram_en),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ovf_err(ovf_err), .unf_err(unf_err), .idx_err(idx_err)
    );

    always #(CLK_P / 2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    logic [37:0] mdl [512];
    bit          vld [512];
    int          m_dsp, m_rsp, m_fp;
    bit          m_ovf, m_unf, m_idx;
    logic [3:0]  rs_op = 4'd0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'd1, 4'd2: return "R2 stack";
            4'd3:       return "R7 call";
            4'd4:       return "R8 return";
            4'd5, 4'd6: return "R5 global";
            default:    return "R6 local";
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        op_code = 4'd0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_dsp = 0; m_rsp = 0; m_fp = 0;
        m_ovf = 0; m_unf = 0; m_idx = 0;
    endtask

    task automatic run_op(input logic [3:0] o, input int ix, input logic [37:0] wd, input logic [15:0] ra);
        int a = 0;
        bit hit = 0, wr = 0, ev = 0;
        logic [37:0] wv, exp;
        exp = '0;
        case (o)
            4'd1: if (m_dsp == 32) m_ovf = 1; else begin hit = 1; wr = 1; a = m_dsp; end
            4'd2: if (m_dsp == 0) m_unf = 1; else begin hit = 1; a = m_dsp - 1; end
            4'd3: if (m_rsp == 16 || m_fp == 12) m_ovf = 1; else begin hit = 1; wr = 1; a = 32 + m_rsp; end
            4'd4: if (m_rsp == 0) m_unf = 1; else begin hit = 1; a = 32 + m_rsp - 1; end
            4'd5, 4'd6: if (ix >= 144) m_idx = 1; else begin hit = 1; wr = (o == 4'd6); a = 48 + ix; end
            4'd7, 4'd8: if (ix >= 24) m_idx = 1; else begin hit = 1; wr = (o == 4'd8); a = 192 + 24 * m_fp + ix; end
            default: ;
        endcase
        wv = (o == 4'd3) ? 38'({4'(m_fp), ra}) : wd;
        @(negedge clk);
        op_code = o; reg_idx = ix[7:0]; wr_data = wd; ret_addr = ra;
        #1;
        chk(ram_en == hit, "R12 access enable", 64'(ram_en), 64'(hit));
        if (hit) begin
            chk(ram_we == wr, {tag_of(o), " write enable"}, 64'(ram_we), 64'(wr));
            chk(32'(ram_addr) == a, {tag_of(o), " address"}, 64'(ram_addr), 64'(a));
            if (wr) chk(ram_wdata == wv, {tag_of(o), " write data"}, 64'(ram_wdata), 64'(wv));
        end
        @(negedge clk);
        if (hit && wr) begin mdl[a] = wv; vld[a] = 1; end
        if (hit && !wr) begin ev = vld[a]; exp = mdl[a]; end
        if (hit) begin
            case (o)
                4'd1: m_dsp++;
                4'd2: m_dsp--;
                4'd3: begin m_rsp++; m_fp++; end
                4'd4: m_rsp--;
                default: ;
            endcase
        end
        chk(rd_valid == (hit && !wr), {tag_of(o), " read valid"}, 64'(rd_valid), 64'(hit && !wr));
        if (hit && !wr && ev) chk(rd_data == exp, {tag_of(o), " read data"}, 64'(rd_data), 64'(exp));
        chk({ovf_err, unf_err, idx_err} == {m_ovf, m_unf, m_idx}, "R11 error flags",
            64'({ovf_err, unf_err, idx_err}), 64'({m_ovf, m_unf, m_idx}));
        if (o == 4'd4 && hit) begin
            chk(ready == 1'b0, "R8 busy in restore", 64'(ready), 64'd0);
            m_fp = int'(exp[19:16]);
            op_code = rs_op;
            @(negedge clk);
            op_code = 4'd0;
            chk(ready == 1'b1, "R8 back to run", 64'(ready), 64'd1);
            chk(rd_valid == 1'b0, "R8 restore op ignored", 64'(rd_valid), 64'd0);
        end else begin
            op_code = 4'd0;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int r;
        void'($urandom(32'h1F3A));
        for (int i = 0; i < 512; i++) vld[i] = 0;
        rst_n = 1'b0; op_code = 4'd0; reg_idx = '0; wr_data = '0; ret_addr = '0;
        do_reset();

        // R1: reset state
        @(negedge clk);
        chk(ready == 1'b1, "R1 ready", 64'(ready), 64'd1);
        chk(rd_valid == 1'b0, "R1 rd_valid", 64'(rd_valid), 64'd0);
        chk({ovf_err, unf_err, idx_err} == 3'b000, "R1 flags", 64'({ovf_err, unf_err, idx_err}), 64'd0);

        // R4 / R10: empty stacks after reset
        run_op(4'd2, 0, '0, '0);
        chk(unf_err == 1'b1, "R4 pop empty", 64'(unf_err), 64'd1);
        do_reset();
        run_op(4'd4, 0, '0, '0);
        chk(unf_err == 1'b1, "R10 return empty", 64'(unf_err), 64'd1);
        run_op(4'd0, 0, '0, '0);
        chk(unf_err == 1'b1, "R11 sticky", 64'(unf_err), 64'd1);

        // R2 / R3: fill, overflow, drain
        do_reset();
        for (int i = 0; i < 32; i++) run_op(4'd1, 0, 38'(64'h2_0000_0000 + i * 7), '0);
        run_op(4'd1, 0, 38'h3F_FFFF_FFFF, '0);
        chk(ovf_err == 1'b1, "R3 push full", 64'(ovf_err), 64'd1);
        for (int i = 0; i < 32; i++) run_op(4'd2, 0, '0, '0);

        // R5 / R6: register boundaries
        do_reset();
        run_op(4'd6, 0, 38'h11, '0);
        run_op(4'd6, 143, 38'h22_2222_2222, '0);
        run_op(4'd5, 143, '0, '0);
        run_op(4'd5, 0, '0, '0);
        run_op(4'd6, 144, 38'h33, '0);
        chk(idx_err == 1'b1, "R5 bad global", 64'(idx_err), 64'd1);
        do_reset();
        run_op(4'd8, 23, 38'hA5, '0);
        run_op(4'd8, 5, 38'h0A, '0);
        run_op(4'd7, 24, '0, '0);
        chk(idx_err == 1'b1, "R6 bad local", 64'(idx_err), 64'd1);

        // R7 / R8: fresh frame, restore
        do_reset();
        run_op(4'd8, 5, 38'hCAFE, '0);
        run_op(4'd3, 0, '0, 16'hBEEF);
        run_op(4'd8, 5, 38'hD00D, '0);
        run_op(4'd7, 5, '0, '0);
        rs_op = 4'd1;
        run_op(4'd4, 0, '0, '0);
        rs_op = 4'd0;
        run_op(4'd7, 5, '0, '0);
        chk(rd_data == 38'hCAFE, "R7 caller local kept", 64'(rd_data), 64'hCAFE);
        run_op(4'd2, 0, '0, '0);
        chk(unf_err == 1'b1, "R8 push during restore ignored", 64'(unf_err), 64'd1);

        // R9 / R10: deep nesting
        do_reset();
        for (int i = 0; i < 12; i++) run_op(4'd3, 0, '0, 16'(16'h100 + i));
        chk(ovf_err == 1'b0, "R9 twelve calls fit", 64'(ovf_err), 64'd0);
        run_op(4'd3, 0, '0, 16'h999);
        chk(ovf_err == 1'b1, "R9 frames exhausted", 64'(ovf_err), 64'd1);
        for (int i = 0; i < 12; i++) run_op(4'd4, 0, '0, '0);
        run_op(4'd4, 0, '0, '0);
        chk(unf_err == 1'b1, "R10 return stack drained", 64'(unf_err), 64'd1);

        // Random mix
        do_reset();
        for (int i = 0; i < 1500; i++) begin
            r = int'($urandom % 10);
            case (r)
                0, 1: run_op(4'd1, 0, 38'({$urandom, $urandom}), '0);
                2, 3: run_op(4'd2, 0, '0, '0);
                4:    run_op(4'd3, 0, '0, 16'($urandom));
                5:    run_op(4'd4, 0, '0, '0);
                6:    run_op(4'd5, int'($urandom % 150), '0, '0);
                7:    run_op(4'd6, int'($urandom % 150), 38'({$urandom, $urandom}), '0);
                8:    run_op(4'd7, int'($urandom % 27), '0, '0);
                default: run_op(4'd8, int'($urandom % 27), 38'({$urandom, $urandom}), '0);
            endcase
            if (i % 500 == 499) do_reset();
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule